// File: doc/BRIEF.md
# Texture Coordinate Address Unit

This unit turns one texture lookup request into the four integer texel positions a bilinear filter reads. A request carries a normalized coordinate pair (u, v), a level-of-detail value and one addressing mode per axis. The unit first picks the mip level from the level-of-detail value. It then scales both coordinates to that level's size and moves them back by half a texel. The floor of the result is the footprint origin, and its fraction gives the two bilinear weights. Finally each corner of the 2x2 footprint is folded into the level, either by wrapping or by clamping, with the mode chosen separately for each axis.

The unit is a three-stage pipeline: level select, scale, fold. Requests arrive on a valid/ready handshake, and results leave on a second handshake toward the texel cache. When the cache side holds off, every stage freezes together. Results come out in the order the requests were accepted.

Top module: `texaddr_unit`

## Requirements
- R1: The output level equals the integer part of the level-of-detail input (its upper 4 bits; the lower 4 bits are the fraction), limited to 6, the highest level for the default 64x32 base.
- R2: At level n the axis size is the base size shifted right by n, with a minimum of 1. For u and v (18 bits, 16 of them fractional), the footprint origin is floor(coord*size - 0.5) on each axis.
- R3: Before folding, the second corner on each axis is the origin plus one. The four corners are (x0,y0), (x1,y0), (x0,y1) and (x1,y1).
- R4: Mode bit 0 selects wrap: each corner is taken modulo the axis size, so a negative origin maps to size-1.
- R5: Mode bit 1 selects clamp: each corner is limited to the range 0 through size-1.
- R6: The u mode affects only the x outputs, and the v mode affects only the y outputs.
- R7: A request accepted on a rising edge has its result valid after the third rising edge, counting the accepting one. Results come out in acceptance order, one per request.
- R8: While a result is valid and not taken, every output holds its value and req_ready is low.
- R9: In reset, rsp_valid is low.
- R10: Each weight is bits 15 down to 8 of the fractional part of coord*size - 0.5 on its axis.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted on this edge when valid |
| req_u | input | 18 | Horizontal coordinate, 2.16 unsigned |
| req_v | input | 18 | Vertical coordinate, 2.16 unsigned |
| req_lod | input | 8 | Level of detail, 4.4 unsigned |
| req_mode_u | input | 1 | x addressing: 0 wrap, 1 clamp |
| req_mode_v | input | 1 | y addressing: 0 wrap, 1 clamp |
| rsp_valid | output | 1 | Result present |
| rsp_ready | input | 1 | Cache side takes the result |
| rsp_level | output | 3 | Selected mip level |
| rsp_x0 | output | 6 | Left texel column |
| rsp_x1 | output | 6 | Right texel column |
| rsp_y0 | output | 5 | Upper texel row |
| rsp_y1 | output | 5 | Lower texel row |
| rsp_wu | output | 8 | Horizontal bilinear weight |
| rsp_wv | output | 8 | Vertical bilinear weight |

## Verification
Two things can happen on the same edge: a new request is taken in while a finished result leaves toward the cache, or a request is offered while the output stage is held. The bench drives a dense random request stream against a randomly toggling rsp_ready, so taking in, handing out and stalling mix on every edge. A queue-based model predicts each footprint from the requirement formulas and compares it whenever a result is shown. While the output is held, the bench also checks that the result stays valid and that no request is taken, so a request lost or duplicated at a stall edge shows up as an ordering or count mismatch.

// File: rtl/texaddr_pkg.sv
package texaddr_pkg;

    typedef enum logic {
        ADDR_WRAP  = 1'b0,
        ADDR_CLAMP = 1'b1
    } addr_mode_e;

    // log2 of an axis size at a given mip level, never below zero
    function automatic int level_log2(input int base_log2, input int lvl);
        return (base_log2 > lvl) ? (base_log2 - lvl) : 0;
    endfunction

endpackage

// File: rtl/texaddr_lvl.sv
module texaddr_lvl
    import texaddr_pkg::*;
#(
    parameter int LOD_W    = 8,
    parameter int LOD_FRAC = 4,
    parameter int LOG2W    = 6,
    parameter int LOG2H    = 5,
    parameter int MAX_LVL  = 6,
    parameter int LVL_W    = 3
) (
    input  logic [LOD_W-1:0] lod,
    output logic [LVL_W-1:0] lvl,
    output logic [LVL_W-1:0] lw,
    output logic [LVL_W-1:0] lh
);
    localparam int LOD_INT = LOD_W - LOD_FRAC;

    logic [LOD_INT-1:0] whole;
    assign whole = lod[LOD_W-1:LOD_FRAC];

    always_comb begin
        if (int'(whole) > MAX_LVL) lvl = LVL_W'(MAX_LVL);
        else                       lvl = LVL_W'(whole);
        lw = LVL_W'(level_log2(LOG2W, int'(lvl)));
        lh = LVL_W'(level_log2(LOG2H, int'(lvl)));
    end
endmodule

// File: rtl/texaddr_scale.sv
module texaddr_scale #(
    parameter int UV_W    = 18,
    parameter int UV_FRAC = 16,
    parameter int MAX_LVL = 6,
    parameter int LVL_W   = 3,
    parameter int CW      = 10,
    parameter int WGT_W   = 8
) (
    input  logic [UV_W-1:0]       coord,
    input  logic [LVL_W-1:0]      shift,
    output logic signed [CW-1:0]  origin,
    output logic [WGT_W-1:0]      weight
);
    localparam int SW = UV_W + MAX_LVL + 1;
    localparam logic [SW-1:0] HALF = SW'(1) << (UV_FRAC - 1);

    logic [SW-1:0]        scaled;
    logic signed [SW-1:0] centred;

    always_comb begin
        scaled  = SW'(coord) << shift;
        centred = $signed(scaled) - $signed(HALF);
        origin  = CW'(centred >>> UV_FRAC);
        weight  = centred[UV_FRAC-1 -: WGT_W];
    end
endmodule

// File: rtl/texaddr_fold.sv
module texaddr_fold
    import texaddr_pkg::*;
#(
    parameter int CW    = 10,
    parameter int LVL_W = 3,
    parameter int OW    = 6
) (
    input  logic signed [CW-1:0] coord,
    input  logic [LVL_W-1:0]     log2_size,
    input  logic                 mode,
    output logic [OW-1:0]        texel
);
    logic signed [CW-1:0] mask;
    logic signed [CW-1:0] folded;
    addr_mode_e           amode;

    assign amode = addr_mode_e'(mode);

    always_comb begin
        mask = $signed((CW'(1) << log2_size) - CW'(1));
        unique case (amode)
            ADDR_WRAP:  folded = coord & mask;
            ADDR_CLAMP: begin
                if (coord < 0)         folded = '0;
                else if (coord > mask) folded = mask;
                else                   folded = coord;
            end
            default:    folded = coord;
        endcase
        texel = OW'(folded);
    end
endmodule

// File: rtl/texaddr_unit.sv
module texaddr_unit
    import texaddr_pkg::*;
#(
    parameter int UV_INT   = 2,
    parameter int UV_FRAC  = 16,
    parameter int LOD_INT  = 4,
    parameter int LOD_FRAC = 4,
    parameter int LOG2W    = 6,
    parameter int LOG2H    = 5,
    parameter int WGT_W    = 8,
    localparam int UV_W    = UV_INT + UV_FRAC,
    localparam int LOD_W   = LOD_INT + LOD_FRAC,
    localparam int MAX_LVL = (LOG2W > LOG2H) ? LOG2W : LOG2H,
    localparam int LVL_W   = (MAX_LVL > 0) ? $clog2(MAX_LVL + 1) : 1,
    localparam int XW      = (LOG2W > 0) ? LOG2W : 1,
    localparam int YW      = (LOG2H > 0) ? LOG2H : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [UV_W-1:0]  req_u,
    input  logic [UV_W-1:0]  req_v,
    input  logic [LOD_W-1:0] req_lod,
    input  logic             req_mode_u,
    input  logic             req_mode_v,
    output logic             rsp_valid,
    input  logic             rsp_ready,
    output logic [LVL_W-1:0] rsp_level,
    output logic [XW-1:0]    rsp_x0,
    output logic [XW-1:0]    rsp_x1,
    output logic [YW-1:0]    rsp_y0,
    output logic [YW-1:0]    rsp_y1,
    output logic [WGT_W-1:0] rsp_wu,
    output logic [WGT_W-1:0] rsp_wv
);
    localparam int CW = UV_INT + MAX_LVL + 2;

    // one enable freezes all three stages together
    logic adv;
    assign adv       = rsp_ready || !rsp_valid;
    assign req_ready = adv;

    // ---------------- stage 1: level select ----------------
    logic [LVL_W-1:0] lvl_c, lw_c, lh_c;
    logic             vld1;
    logic [UV_W-1:0]  u1, v1;
    logic             mu1, mv1;
    logic [LVL_W-1:0] lvl1, lw1, lh1;

    texaddr_lvl #(
        .LOD_W(LOD_W), .LOD_FRAC(LOD_FRAC), .LOG2W(LOG2W), .LOG2H(LOG2H),
        .MAX_LVL(MAX_LVL), .LVL_W(LVL_W)
    ) u_lvl (
        .lod(req_lod), .lvl(lvl_c), .lw(lw_c), .lh(lh_c)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vld1 <= 1'b0;
            u1   <= '0;
            v1   <= '0;
            mu1  <= 1'b0;
            mv1  <= 1'b0;
            lvl1 <= '0;
            lw1  <= '0;
            lh1  <= '0;
        end else if (adv) begin
            vld1 <= req_valid;
            u1   <= req_u;
            v1   <= req_v;
            mu1  <= req_mode_u;
            mv1  <= req_mode_v;
            lvl1 <= lvl_c;
            lw1  <= lw_c;
            lh1  <= lh_c;
        end
    end

    // ---------------- stage 2: scale to level ----------------
    logic signed [CW-1:0] ox_c, oy_c;
    logic [WGT_W-1:0]     wu_c, wv_c;
    logic                 vld2;
    logic signed [CW-1:0] ox2, oy2;
    logic [WGT_W-1:0]     wu2, wv2;
    logic                 mu2, mv2;
    logic [LVL_W-1:0]     lvl2, lw2, lh2;

    texaddr_scale #(
        .UV_W(UV_W), .UV_FRAC(UV_FRAC), .MAX_LVL(MAX_LVL), .LVL_W(LVL_W),
        .CW(CW), .WGT_W(WGT_W)
    ) u_scale_x (
        .coord(u1), .shift(lw1), .origin(ox_c), .weight(wu_c)
    );

    texaddr_scale #(
        .UV_W(UV_W), .UV_FRAC(UV_FRAC), .MAX_LVL(MAX_LVL), .LVL_W(LVL_W),
        .CW(CW), .WGT_W(WGT_W)
    ) u_scale_y (
        .coord(v1), .shift(lh1), .origin(oy_c), .weight(wv_c)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vld2 <= 1'b0;
            ox2  <= '0;
            oy2  <= '0;
            wu2  <= '0;
            wv2  <= '0;
            mu2  <= 1'b0;
            mv2  <= 1'b0;
            lvl2 <= '0;
            lw2  <= '0;
            lh2  <= '0;
        end else if (adv) begin
            vld2 <= vld1;
            ox2  <= ox_c;
            oy2  <= oy_c;
            wu2  <= wu_c;
            wv2  <= wv_c;
            mu2  <= mu1;
            mv2  <= mv1;
            lvl2 <= lvl1;
            lw2  <= lw1;
            lh2  <= lh1;
        end
    end

    // ---------------- stage 3: corner fold ----------------
    logic [XW-1:0] xt [2];
    logic [YW-1:0] yt [2];

    for (genvar c = 0; c < 2; c++) begin : g_corner
        logic signed [CW-1:0] xc, yc;
        assign xc = ox2 + CW'(c);
        assign yc = oy2 + CW'(c);

        texaddr_fold #(.CW(CW), .LVL_W(LVL_W), .OW(XW)) u_fold_x (
            .coord(xc), .log2_size(lw2), .mode(mu2), .texel(xt[c])
        );
        texaddr_fold #(.CW(CW), .LVL_W(LVL_W), .OW(YW)) u_fold_y (
            .coord(yc), .log2_size(lh2), .mode(mv2), .texel(yt[c])
        );
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_level <= '0;
            rsp_x0    <= '0;
            rsp_x1    <= '0;
            rsp_y0    <= '0;
            rsp_y1    <= '0;
            rsp_wu    <= '0;
            rsp_wv    <= '0;
        end else if (adv) begin
            rsp_valid <= vld2;
            rsp_level <= lvl2;
            rsp_x0    <= xt[0];
            rsp_x1    <= xt[1];
            rsp_y0    <= yt[0];
            rsp_y1    <= yt[1];
            rsp_wu    <= wu2;
            rsp_wv    <= wv2;
        end
    end

    // ---------------- assertions ----------------
    logic [XW-1:0] xmask_o;
    logic [YW-1:0] ymask_o;
    assign xmask_o = XW'((1 << level_log2(LOG2W, int'(rsp_level))) - 1);
    assign ymask_o = YW'((1 << level_log2(LOG2H, int'(rsp_level))) - 1);

    assert_level_cap_R1: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (int'(rsp_level) <= MAX_LVL));

    assert_xstep_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> ((rsp_x1 == ((rsp_x0 + XW'(1)) & xmask_o)) || (rsp_x1 == rsp_x0)));

    assert_ystep_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> ((rsp_y1 == ((rsp_y0 + YW'(1)) & ymask_o)) || (rsp_y1 == rsp_y0)));

    assert_xrange_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (rsp_x0 <= xmask_o && rsp_x1 <= xmask_o));

    assert_yrange_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (rsp_y0 <= ymask_o && rsp_y1 <= ymask_o));

    assert_no_accept_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_ready) |-> !req_ready);

    assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_level) &&
            $stable(rsp_x0) && $stable(rsp_x1) && $stable(rsp_y0) &&
            $stable(rsp_y1) && $stable(rsp_wu) && $stable(rsp_wv)));

    assert_advance_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (vld2 && adv) |=> rsp_valid);
endmodule

// File: tb/texaddr_unit_test.sv
module texaddr_unit_test;
    localparam int CLK_PERIOD = 10;
    localparam int LW2 = 6;
    localparam int LH2 = 5;
    localparam int MAXL = 6;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [17:0] req_u = '0;
    logic [17:0] req_v = '0;
    logic [7:0]  req_lod = '0;
    logic        req_mode_u = 1'b0;
    logic        req_mode_v = 1'b0;
    logic        rsp_valid;
    logic        rsp_ready = 1'b1;
    logic [2:0]  rsp_level;
    logic [5:0]  rsp_x0, rsp_x1;
    logic [4:0]  rsp_y0, rsp_y1;
    logic [7:0]  rsp_wu, rsp_wv;

    texaddr_unit uut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_u(req_u), .req_v(req_v), .req_lod(req_lod),
        .req_mode_u(req_mode_u), .req_mode_v(req_mode_v),
        .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
        .rsp_level(rsp_level), .rsp_x0(rsp_x0), .rsp_x1(rsp_x1),
        .rsp_y0(rsp_y0), .rsp_y1(rsp_y1), .rsp_wu(rsp_wu), .rsp_wv(rsp_wv)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    typedef struct {
        int lvl; int x0; int x1; int y0; int y1; int wu; int wv;
    } exp_t;

    exp_t q[$];
    int   total = 0;
    int   bad = 0;
    bit   finished = 0;
    bit   was_stalled = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic int fold(input longint x, input int lsz, input bit clamp);
        longint size = longint'(1) << lsz;
        if (!clamp) return int'(((x % size) + size) % size);
        if (x < 0) return 0;
        if (x > size - 1) return int'(size - 1);
        return int'(x);
    endfunction

    function automatic void axis(input longint c, input int lsz, input bit clamp,
                                 output int t0, output int t1, output int w);
        longint s = c * (longint'(1) << lsz) - 32768;
        longint o = (s >= 0) ? (s / 65536) : -((-s + 65535) / 65536);
        w  = int'((s - o * 65536) / 256);
        t0 = fold(o, lsz, clamp);
        t1 = fold(o + 1, lsz, clamp);
    endfunction

    function automatic exp_t model(input logic [17:0] u, input logic [17:0] v,
                                   input logic [7:0] lod, input bit mu, input bit mv);
        exp_t e;
        int lw, lh;
        e.lvl = int'(lod) / 16;
        if (e.lvl > MAXL) e.lvl = MAXL;
        lw = (LW2 > e.lvl) ? LW2 - e.lvl : 0;
        lh = (LH2 > e.lvl) ? LH2 - e.lvl : 0;
        axis(longint'(u), lw, mu, e.x0, e.x1, e.wu);
        axis(longint'(v), lh, mv, e.y0, e.y1, e.wv);
        return e;
    endfunction

    // inputs are set by the caller; compare, update the model, cross one edge
    task automatic tick();
        #1;
        if (was_stalled) chk(rsp_valid == 1'b1, "R8", "held valid", rsp_valid, 1);
        if (rsp_valid && !rsp_ready)
            chk(req_ready == 1'b0, "R8", "ready while held", req_ready, 0);
        if (rsp_valid) begin
            if (q.size() == 0) chk(0, "R7", "output without request", 1, 0);
            else begin
                exp_t e = q[0];
                chk(int'(rsp_level) == e.lvl, "R1", "level", rsp_level, e.lvl);
                chk(int'(rsp_x0) == e.x0, "R2 R4 R5", "x0", rsp_x0, e.x0);
                chk(int'(rsp_x1) == e.x1, "R3 R4 R5", "x1", rsp_x1, e.x1);
                chk(int'(rsp_y0) == e.y0, "R2 R4 R5", "y0", rsp_y0, e.y0);
                chk(int'(rsp_y1) == e.y1, "R3 R4 R5", "y1", rsp_y1, e.y1);
                chk(int'(rsp_wu) == e.wu, "R10", "wu", rsp_wu, e.wu);
                chk(int'(rsp_wv) == e.wv, "R10", "wv", rsp_wv, e.wv);
                if (rsp_ready) void'(q.pop_front());
            end
        end
        was_stalled = rsp_valid && !rsp_ready;
        if (req_valid && req_ready)
            q.push_back(model(req_u, req_v, req_lod, req_mode_u, req_mode_v));
        @(negedge clk);
    endtask

    // one request with the output side open; returns when its result is shown
    task automatic run_one(input logic [17:0] u, input logic [17:0] v,
                           input logic [7:0] lod, input bit mu, input bit mv);
        rsp_ready = 1'b1;
        req_u = u; req_v = v; req_lod = lod; req_mode_u = mu; req_mode_v = mv;
        req_valid = 1'b1;
        tick();
        req_valid = 1'b0;
        chk(rsp_valid == 1'b0, "R7", "valid after edge 1", rsp_valid, 0);
        tick();
        chk(rsp_valid == 1'b0, "R7", "valid after edge 2", rsp_valid, 0);
        tick();
        chk(rsp_valid == 1'b1, "R7", "valid after edge 3", rsp_valid, 1);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        chk(0, "R7", "watchdog expired", 0, 1);
        finish_run();
    end

    initial begin
        @(negedge clk);
        #1;
        chk(rsp_valid == 1'b0, "R9", "valid in reset", rsp_valid, 0);
        chk(req_ready == 1'b1, "R9", "ready in reset", req_ready, 1);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R4: wrap at zero, origin -1 goes to size-1; R10 weight is one half
        run_one(18'h00000, 18'h00000, 8'h00, 1'b0, 1'b0);
        chk(rsp_x0 == 6'd63 && rsp_x1 == 6'd0, "R4", "x wrap", rsp_x0, 63);
        chk(rsp_y0 == 5'd31 && rsp_y1 == 5'd0, "R4", "y wrap", rsp_y0, 31);
        chk(rsp_wu == 8'd128, "R10", "half weight", rsp_wu, 128);
        tick();

        // R5: clamp at zero
        run_one(18'h00000, 18'h00000, 8'h00, 1'b1, 1'b1);
        chk(rsp_x0 == 6'd0 && rsp_x1 == 6'd0, "R5", "x clamp", rsp_x0, 0);
        tick();

        // R6: u wraps while v clamps
        run_one(18'h00000, 18'h00000, 8'h00, 1'b0, 1'b1);
        chk(rsp_x0 == 6'd63 && rsp_y0 == 5'd0, "R6", "mixed modes", rsp_x0, 63);
        tick();

        // R1: level capped at 6, both sizes collapse to one texel
        run_one(18'h08000, 18'h0C000, 8'hF0, 1'b0, 1'b0);
        chk(rsp_level == 3'd6, "R1", "level cap", rsp_level, 6);
        chk(rsp_x1 == 6'd0 && rsp_y1 == 5'd0, "R1", "unit size", rsp_x1, 0);
        tick();

        // R2 R3: u = 1.5 wraps to 31/32; v = 0.375 gives row 11/12
        run_one(18'h18000, 18'h06000, 8'h03, 1'b0, 1'b1);
        chk(rsp_x0 == 6'd31, "R2", "origin x", rsp_x0, 31);
        chk(rsp_x1 == 6'd32, "R3", "corner x1", rsp_x1, 32);
        chk(rsp_y0 == 5'd11 && rsp_y1 == 5'd12, "R2", "origin y", rsp_y0, 11);
        tick();

        // R8: stall holds the result and blocks new requests
        rsp_ready = 1'b0;
        req_u = 18'h0A5A5; req_v = 18'h13C3C; req_lod = 8'h21;
        req_mode_u = 1'b1; req_mode_v = 1'b0; req_valid = 1'b1;
        tick();
        req_u = 18'h3FFFF; req_lod = 8'h00;
        repeat (6) tick();
        chk(rsp_valid == 1'b1, "R8", "stalled valid", rsp_valid, 1);
        rsp_ready = 1'b1;
        req_valid = 1'b0;
        repeat (6) tick();

        // random mix of requests and back-pressure
        for (int i = 0; i < 4000; i++) begin
            req_valid  = ($urandom_range(0, 9) < 7);
            rsp_ready  = ($urandom_range(0, 9) < 6);
            req_u      = 18'($urandom);
            req_v      = 18'($urandom);
            if ($urandom_range(0, 7) == 0) req_u = 18'($urandom_range(0, 3)) << 16;
            req_lod    = 8'($urandom_range(0, 127));
            req_mode_u = 1'($urandom);
            req_mode_v = 1'($urandom);
            tick();
        end
        req_valid = 1'b0;
        rsp_ready = 1'b1;
        repeat (8) tick();
        chk(q.size() == 0, "R7", "all results delivered", q.size(), 0);
        finish_run();
    end
endmodule